// File: doc/BRIEF.md
# Handset Power-Unit Sequencer

This block is the state machine that wakes a handset power unit, supervises its main (core) regulator while the host processor comes out of reset, and takes the unit down again. Analog comparators outside the block give it digital flags: the battery is above the power-on-reset level, the battery is ready (at or above 3.0 V), an undervoltage trip, and the core regulator is either good (at or above 93 % of nominal) or sagging (below 85 %). It also receives four wake sources (on key, hands-free supply, charger, alarm), a keep-alive level from the host processor and a 1 ms enable pulse. It drives three regulator enables, the undervoltage guard enable, the backup-cell charger enable and an active-low host reset.

Every timed wait is counted in ticks of the 1 ms pulse by one shared down-counter. The counter is reloaded each time the machine enters a state, and also on every cycle of RUNNING while keep-alive is high. All comparator, wake and keep-alive inputs pass through two-flop synchronizers. A low level on `batt_above_por` clears the machine at once, whatever the clock is doing. The states are POWEROFF, EXT_STANDBY, STANDBY, TURNON_LDOS, RESET_DELAY, HOLD_WAIT, RUNNING and BROWNOUT.

The transitions are these. From POWEROFF the machine goes to STANDBY when the battery is ready, or to EXT_STANDBY when a charger or hands-free supply is present and the battery is not ready. EXT_STANDBY goes to TURNON_LDOS when the battery becomes ready, and falls back to POWEROFF if the external supply goes away. STANDBY goes to TURNON_LDOS on a wake edge. TURNON_LDOS goes to RESET_DELAY when the core regulator is good, and to POWEROFF on timeout or undervoltage. RESET_DELAY goes to HOLD_WAIT on timeout. HOLD_WAIT goes to RUNNING when keep-alive is high, and to POWEROFF on timeout or undervoltage. RESET_DELAY and HOLD_WAIT both go to BROWNOUT when the core regulator sags. BROWNOUT goes back to RESET_DELAY when the regulator is good again, and to POWEROFF on timeout or undervoltage. RUNNING goes to POWEROFF only when the keep-alive-low timer expires.

Top module: `pmu_seq_top`

## Requirements
- R1: While `batt_above_por` is low, the block is in POWEROFF at once, with no clock edge needed. The output vector {core_ldo_en, aux_ldo_a_en, aux_ldo_b_en, uv_guard_en, backup_chg_en, host_rst_n} then reads 000100.
- R2: In POWEROFF, a charger or hands-free supply with the battery not ready moves the block to EXT_STANDBY, whose outputs read 000100. When the battery becomes ready, EXT_STANDBY moves to TURNON_LDOS, whose outputs read 111110.
- R3: In POWEROFF, a ready battery moves the block to STANDBY, where the backup charger is enabled (outputs 000110).
- R4: In STANDBY, a rising edge on any of the four wake inputs moves the block to TURNON_LDOS (outputs 111110). A wake input that stays high causes no new wake-up.
- R5: In TURNON_LDOS, core good moves the block to RESET_DELAY. If core good has not appeared within T_RISE_MS ticks, the block returns to POWEROFF.
- R6: RESET_DELAY holds host_rst_n low for T_RSTDLY_MS ticks, then releases it and enters HOLD_WAIT (outputs 111111).
- R7: In HOLD_WAIT, keep-alive high moves the block to RUNNING. If keep-alive has not risen within T_HOLDACK_MS ticks, the block powers down.
- R8: An undervoltage trip in TURNON_LDOS, RESET_DELAY, HOLD_WAIT or BROWNOUT powers the block down.
- R9: Core sag in RESET_DELAY or HOLD_WAIT moves the block to BROWNOUT with host_rst_n low. If core good returns within T_BROWN_MS ticks, the block re-enters RESET_DELAY. Otherwise it powers down.
- R10: RUNNING is left only after keep-alive has been low for T_HOLDLOW_MS ticks in a row. Wake inputs and the undervoltage trip have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| batt_above_por | input | 1 | Battery above the reset level; low clears the machine asynchronously |
| batt_ready | input | 1 | Battery at or above 3.0 V |
| uv_trip | input | 1 | Undervoltage lockout event |
| core_ok | input | 1 | Core regulator at or above 93 % of nominal |
| core_sag | input | 1 | Core regulator below 85 % of nominal |
| wake_key | input | 1 | On key pressed |
| wake_handsfree | input | 1 | Hands-free supply present |
| wake_charger | input | 1 | Charger present |
| wake_alarm | input | 1 | Alarm request |
| host_keepalive | input | 1 | Keep-alive level from the host processor |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| core_ldo_en | output | 1 | Core regulator enable |
| aux_ldo_a_en | output | 1 | First auxiliary regulator enable |
| aux_ldo_b_en | output | 1 | Second auxiliary regulator enable |
| uv_guard_en | output | 1 | Undervoltage lockout enable |
| backup_chg_en | output | 1 | Backup cell charger enable |
| host_rst_n | output | 1 | Active-low host reset |

## Verification
The bench builds the block with timeouts of 6, 4, 5, 7 and 5 ticks (rise, reset delay, keep-alive acknowledge, brownout, keep-alive low), and drives a tick every 10 clocks. With these values every timeout fits in a few hundred cycles. Each one can be checked one tick before it expires and again just after, and a single run covers the regulator-rise failure, the missing keep-alive, brownout recovery, brownout expiry, and a short keep-alive drop next to a long one.

// File: rtl/pmu_seq_pkg.sv
package pmu_seq_pkg;

    typedef enum logic [3:0] {
        ST_POWEROFF,
        ST_EXT_STANDBY,
        ST_STANDBY,
        ST_TURNON_LDOS,
        ST_RESET_DELAY,
        ST_HOLD_WAIT,
        ST_RUNNING,
        ST_BROWNOUT
    } seq_state_e;

    typedef struct packed {
        logic core_ldo;
        logic aux_a;
        logic aux_b;
        logic uv_guard;
        logic backup_chg;
        logic host_rst_n;
    } pwr_ctl_t;

    // Bit positions inside the synchronized input vector
    localparam int unsigned SI_BATT   = 0;
    localparam int unsigned SI_UV     = 1;
    localparam int unsigned SI_OK     = 2;
    localparam int unsigned SI_SAG    = 3;
    localparam int unsigned SI_KEEP   = 4;
    localparam int unsigned SI_WAKE0  = 5;
    localparam int unsigned N_WAKE    = 4;
    localparam int unsigned N_SYNC_IN = SI_WAKE0 + N_WAKE;

    // Wake vector order
    localparam int unsigned WK_KEY = 0;
    localparam int unsigned WK_HF  = 1;
    localparam int unsigned WK_CHG = 2;
    localparam int unsigned WK_ALM = 3;

endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d[i]};
            end
        end
        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/pmu_timer.sv
module pmu_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pmu_seq_fsm.sv
module pmu_seq_fsm
    import pmu_seq_pkg::*;
#(
    parameter int unsigned CW          = 8,
    parameter int unsigned T_RISE_MS    = 60,
    parameter int unsigned T_RSTDLY_MS  = 40,
    parameter int unsigned T_HOLDACK_MS = 35,
    parameter int unsigned T_BROWN_MS   = 90,
    parameter int unsigned T_HOLDLOW_MS = 35
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              batt_ready,
    input  logic              uv_trip,
    input  logic              core_ok,
    input  logic              core_sag,
    input  logic              keepalive,
    input  logic [N_WAKE-1:0] wake,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output pwr_ctl_t          ctl,
    output seq_state_e        state_o
);

    seq_state_e        st_q, st_nxt;
    logic [N_WAKE-1:0] wake_q;
    logic              wake_edge;
    logic              ext_supply;

    assign wake_edge  = |(wake & ~wake_q);
    assign ext_supply = wake[WK_HF] | wake[WK_CHG];

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= ST_POWEROFF;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Wake history for edge detection
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            wake_q <= '0;
        end else begin
            wake_q <= wake;
        end
    end

    // Next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_POWEROFF: begin
                if (batt_ready)      st_nxt = ST_STANDBY;
                else if (ext_supply) st_nxt = ST_EXT_STANDBY;
            end
            ST_EXT_STANDBY: begin
                if (batt_ready)       st_nxt = ST_TURNON_LDOS;
                else if (!ext_supply) st_nxt = ST_POWEROFF;
            end
            ST_STANDBY: begin
                if (wake_edge) st_nxt = ST_TURNON_LDOS;
            end
            ST_TURNON_LDOS: begin
                if (uv_trip)          st_nxt = ST_POWEROFF;
                else if (core_ok)     st_nxt = ST_RESET_DELAY;
                else if (tmr_expired) st_nxt = ST_POWEROFF;
            end
            ST_RESET_DELAY: begin
                if (uv_trip)          st_nxt = ST_POWEROFF;
                else if (core_sag)    st_nxt = ST_BROWNOUT;
                else if (tmr_expired) st_nxt = ST_HOLD_WAIT;
            end
            ST_HOLD_WAIT: begin
                if (uv_trip)          st_nxt = ST_POWEROFF;
                else if (core_sag)    st_nxt = ST_BROWNOUT;
                else if (keepalive)   st_nxt = ST_RUNNING;
                else if (tmr_expired) st_nxt = ST_POWEROFF;
            end
            ST_RUNNING: begin
                if (!keepalive && tmr_expired) st_nxt = ST_POWEROFF;
            end
            ST_BROWNOUT: begin
                if (uv_trip)                  st_nxt = ST_POWEROFF;
                else if (core_ok && !core_sag) st_nxt = ST_RESET_DELAY;
                else if (tmr_expired)          st_nxt = ST_POWEROFF;
            end
            default: st_nxt = ST_POWEROFF;
        endcase
    end

    // Timer reload: on every state entry, and while keep-alive holds in RUNNING
    always_comb begin
        tmr_load = (st_nxt != st_q) || ((st_q == ST_RUNNING) && keepalive);
        unique case (st_nxt)
            ST_TURNON_LDOS: tmr_val = CW'(T_RISE_MS);
            ST_RESET_DELAY: tmr_val = CW'(T_RSTDLY_MS);
            ST_HOLD_WAIT:   tmr_val = CW'(T_HOLDACK_MS);
            ST_BROWNOUT:    tmr_val = CW'(T_BROWN_MS);
            ST_RUNNING:     tmr_val = CW'(T_HOLDLOW_MS);
            default:        tmr_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        ctl = '{core_ldo: 1'b0, aux_a: 1'b0, aux_b: 1'b0,
                uv_guard: 1'b1, backup_chg: 1'b0, host_rst_n: 1'b0};
        unique case (st_q)
            ST_POWEROFF, ST_EXT_STANDBY: ;
            ST_STANDBY: ctl.backup_chg = 1'b1;
            ST_TURNON_LDOS, ST_RESET_DELAY, ST_BROWNOUT: begin
                ctl.core_ldo   = 1'b1;
                ctl.aux_a      = 1'b1;
                ctl.aux_b      = 1'b1;
                ctl.backup_chg = 1'b1;
            end
            ST_HOLD_WAIT, ST_RUNNING: begin
                ctl.core_ldo   = 1'b1;
                ctl.aux_a      = 1'b1;
                ctl.aux_b      = 1'b1;
                ctl.backup_chg = 1'b1;
                ctl.host_rst_n = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = st_q;

endmodule

// File: rtl/pmu_seq_top.sv
module pmu_seq_top
    import pmu_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned T_RISE_MS    = 60,
    parameter int unsigned T_RSTDLY_MS  = 40,
    parameter int unsigned T_HOLDACK_MS = 35,
    parameter int unsigned T_BROWN_MS   = 90,
    parameter int unsigned T_HOLDLOW_MS = 35
) (
    input  logic clk,
    input  logic batt_above_por,
    input  logic batt_ready,
    input  logic uv_trip,
    input  logic core_ok,
    input  logic core_sag,
    input  logic wake_key,
    input  logic wake_handsfree,
    input  logic wake_charger,
    input  logic wake_alarm,
    input  logic host_keepalive,
    input  logic tick_1ms,
    output logic core_ldo_en,
    output logic aux_ldo_a_en,
    output logic aux_ldo_b_en,
    output logic uv_guard_en,
    output logic backup_chg_en,
    output logic host_rst_n
);

    localparam int unsigned T_MAX_A = (T_RISE_MS > T_RSTDLY_MS) ? T_RISE_MS : T_RSTDLY_MS;
    localparam int unsigned T_MAX_B = (T_HOLDACK_MS > T_BROWN_MS) ? T_HOLDACK_MS : T_BROWN_MS;
    localparam int unsigned T_MAX_C = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int unsigned T_MAX   = (T_MAX_C > T_HOLDLOW_MS) ? T_MAX_C : T_HOLDLOW_MS;
    localparam int unsigned CW      = $clog2(T_MAX + 1);

    logic [N_SYNC_IN-1:0] raw_in, syn_in;
    logic [N_WAKE-1:0]    wake_s;
    logic                 batt_s, uv_s, ok_s, sag_s, keep_s;
    logic                 tmr_load, tmr_exp;
    logic [CW-1:0]        tmr_val;
    pwr_ctl_t             ctl;
    seq_state_e           st_w;

    always_comb begin
        raw_in                  = '0;
        raw_in[SI_BATT]         = batt_ready;
        raw_in[SI_UV]           = uv_trip;
        raw_in[SI_OK]           = core_ok;
        raw_in[SI_SAG]          = core_sag;
        raw_in[SI_KEEP]         = host_keepalive;
        raw_in[SI_WAKE0+WK_KEY] = wake_key;
        raw_in[SI_WAKE0+WK_HF]  = wake_handsfree;
        raw_in[SI_WAKE0+WK_CHG] = wake_charger;
        raw_in[SI_WAKE0+WK_ALM] = wake_alarm;
    end

    pmu_sync #(.WIDTH(N_SYNC_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (batt_above_por),
        .d      (raw_in),
        .q      (syn_in)
    );

    assign batt_s = syn_in[SI_BATT];
    assign uv_s   = syn_in[SI_UV];
    assign ok_s   = syn_in[SI_OK];
    assign sag_s  = syn_in[SI_SAG];
    assign keep_s = syn_in[SI_KEEP];
    assign wake_s = syn_in[SI_WAKE0 +: N_WAKE];

    pmu_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .arst_n   (batt_above_por),
        .tick     (tick_1ms),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    pmu_seq_fsm #(
        .CW           (CW),
        .T_RISE_MS    (T_RISE_MS),
        .T_RSTDLY_MS  (T_RSTDLY_MS),
        .T_HOLDACK_MS (T_HOLDACK_MS),
        .T_BROWN_MS   (T_BROWN_MS),
        .T_HOLDLOW_MS (T_HOLDLOW_MS)
    ) u_fsm (
        .clk         (clk),
        .arst_n      (batt_above_por),
        .batt_ready  (batt_s),
        .uv_trip     (uv_s),
        .core_ok     (ok_s),
        .core_sag    (sag_s),
        .keepalive   (keep_s),
        .wake        (wake_s),
        .tmr_expired (tmr_exp),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ctl         (ctl),
        .state_o     (st_w)
    );

    assign core_ldo_en   = ctl.core_ldo;
    assign aux_ldo_a_en  = ctl.aux_a;
    assign aux_ldo_b_en  = ctl.aux_b;
    assign uv_guard_en   = ctl.uv_guard;
    assign backup_chg_en = ctl.backup_chg;
    assign host_rst_n    = ctl.host_rst_n;

endmodule

// File: rtl/pmu_seq_checker.sv
module pmu_seq_checker
    import pmu_seq_pkg::*;
(
    input logic       clk,
    input logic       arst_n,
    input seq_state_e state,
    input logic       hold_s,
    input logic       uv_s,
    input logic       batt_s,
    input logic       tmr_exp,
    input logic       host_rst_n,
    input logic       core_ldo_en,
    input logic       backup_chg_en
);

    AST_RST_HELD_WITHOUT_CORE: assert property (@(posedge clk) disable iff (!arst_n)
        !core_ldo_en |-> !host_rst_n) else $error("reset released with core off"); // R1

    AST_CORE_ON_FROM_STANDBY: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_ldo_en) |-> ($past(state) == ST_STANDBY || $past(state) == ST_EXT_STANDBY))
        else $error("regulators woke from wrong state"); // R4

    AST_BACKUP_NEEDS_BATT: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(backup_chg_en) |-> $past(batt_s)) else $error("backup charge without battery"); // R3

    AST_TURNON_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(state) == ST_TURNON_LDOS && state == ST_POWEROFF) |-> ($past(tmr_exp) || $past(uv_s)))
        else $error("early turn-on abort"); // R5

    AST_RST_RELEASE_TIMED: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(host_rst_n) |-> $past(tmr_exp)) else $error("reset released early"); // R6

    AST_RUN_EXIT_BY_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(state) == ST_RUNNING && state != ST_RUNNING) |-> ($past(!hold_s) && $past(tmr_exp)))
        else $error("running left without keep-alive timeout"); // R10

endmodule

bind pmu_seq_top pmu_seq_checker u_chk (
    .clk           (clk),
    .arst_n        (batt_above_por),
    .state         (st_w),
    .hold_s        (keep_s),
    .uv_s          (uv_s),
    .batt_s        (batt_s),
    .tmr_exp       (tmr_exp),
    .host_rst_n    (host_rst_n),
    .core_ldo_en   (core_ldo_en),
    .backup_chg_en (backup_chg_en)
);

// File: tb/pmu_seq_top_bench.sv
module pmu_seq_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 10;
    localparam int T_RISE     = 6;
    localparam int T_RSTDLY   = 4;
    localparam int T_HOLDACK  = 5;
    localparam int T_BROWN    = 7;
    localparam int T_HOLDLOW  = 5;

    // {core, aux_a, aux_b, uv_guard, backup, host_rst_n}
    localparam logic [5:0] E_OFF = 6'b000100;
    localparam logic [5:0] E_SBY = 6'b000110;
    localparam logic [5:0] E_SEQ = 6'b111110;
    localparam logic [5:0] E_ON  = 6'b111111;

    logic clk = 1'b0;
    logic batt_above_por = 1'b0, batt_ready = 1'b0, uv_trip = 1'b0;
    logic core_ok = 1'b0, core_sag = 1'b0;
    logic wake_key = 1'b0, wake_handsfree = 1'b0, wake_charger = 1'b0, wake_alarm = 1'b0;
    logic host_keepalive = 1'b0, tick_1ms = 1'b0;
    logic core_ldo_en, aux_ldo_a_en, aux_ldo_b_en, uv_guard_en, backup_chg_en, host_rst_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [5:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    pmu_seq_top #(
        .T_RISE_MS    (T_RISE),
        .T_RSTDLY_MS  (T_RSTDLY),
        .T_HOLDACK_MS (T_HOLDACK),
        .T_BROWN_MS   (T_BROWN),
        .T_HOLDLOW_MS (T_HOLDLOW)
    ) u_pmu_seq_top (
        .clk            (clk),
        .batt_above_por (batt_above_por),
        .batt_ready     (batt_ready),
        .uv_trip        (uv_trip),
        .core_ok        (core_ok),
        .core_sag       (core_sag),
        .wake_key       (wake_key),
        .wake_handsfree (wake_handsfree),
        .wake_charger   (wake_charger),
        .wake_alarm     (wake_alarm),
        .host_keepalive (host_keepalive),
        .tick_1ms       (tick_1ms),
        .core_ldo_en    (core_ldo_en),
        .aux_ldo_a_en   (aux_ldo_a_en),
        .aux_ldo_b_en   (aux_ldo_b_en),
        .uv_guard_en    (uv_guard_en),
        .backup_chg_en  (backup_chg_en),
        .host_rst_n     (host_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generator: one-cycle pulse every TICK_DIV clocks
    initial begin
        forever begin
            repeat (TICK_DIV-1) @(negedge clk);
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
        end
    end

    // Monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            sb_item_t it;
            logic [5:0] act;
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = {core_ldo_en, aux_ldo_a_en, aux_ldo_b_en, uv_guard_en, backup_chg_en, host_rst_n};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_out(input string tag, input logic [5:0] e);
        sb_item_t it;
        it.tag = tag;
        it.exp = e;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Returns just after the clock edge that consumed the n-th tick
    task automatic wait_ticks(input int n);
        repeat (n) begin
            wait (tick_1ms);
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        cyc(3);
        expect_out("R1 reset state", E_OFF);
        batt_above_por = 1'b1;
        cyc(5);
        expect_out("R1 idle after reset", E_OFF);

        // R2: external supply with battery low, then battery ready
        wake_charger = 1'b1;
        cyc(5);
        expect_out("R2 ext standby outputs", E_OFF);
        wait_ticks(1);
        batt_ready = 1'b1;
        cyc(4);
        expect_out("R2 battery ready starts turn-on", E_SEQ);

        // R5: core never good
        wait_ticks(T_RISE-1); cyc(3);
        expect_out("R5 still turning on before timeout", E_SEQ);
        wait_ticks(1); cyc(3);
        expect_out("R5 rise timeout then R3 standby", E_SBY);

        // R4: level held high does not wake
        wake_charger = 1'b0;
        cyc(5);
        expect_out("R4 no edge stays standby", E_SBY);
        wait_ticks(1);
        wake_key = 1'b1;
        cyc(4);
        expect_out("R4 key edge wakes", E_SEQ);
        wake_key = 1'b0;

        // R6: reset delay
        wait_ticks(1);
        core_ok = 1'b1;
        cyc(4);
        expect_out("R6 reset held on entry", E_SEQ);
        wait_ticks(T_RSTDLY-1); cyc(3);
        expect_out("R6 reset held before delay end", E_SEQ);
        wait_ticks(1); cyc(3);
        expect_out("R6 reset released", E_ON);

        // R7: no keep-alive
        wait_ticks(T_HOLDACK-1); cyc(3);
        expect_out("R7 waiting for keep-alive", E_ON);
        wait_ticks(1); cyc(3);
        expect_out("R7 keep-alive timeout powers down", E_SBY);

        // R8: undervoltage while waiting for keep-alive
        wait_ticks(1);
        wake_alarm = 1'b1;
        cyc(4);
        expect_out("R4 alarm edge wakes", E_SEQ);
        wake_alarm = 1'b0;
        wait_ticks(T_RSTDLY); cyc(3);
        expect_out("R8 reached hold wait", E_ON);
        uv_trip = 1'b1;
        cyc(5);
        expect_out("R8 undervoltage powers down", E_SBY);
        uv_trip = 1'b0;

        // R7/R10: running
        wait_ticks(1);
        wake_handsfree = 1'b1;
        cyc(4);
        expect_out("R4 hands-free edge wakes", E_SEQ);
        wait_ticks(T_RSTDLY); cyc(3);
        host_keepalive = 1'b1;
        cyc(4);
        wait_ticks(T_HOLDACK+2); cyc(3);
        expect_out("R7 keep-alive reached running", E_ON);
        uv_trip = 1'b1; wake_key = 1'b1; wake_charger = 1'b1; wake_alarm = 1'b1;
        cyc(6);
        expect_out("R10 wake and undervoltage ignored", E_ON);
        uv_trip = 1'b0; wake_key = 1'b0; wake_charger = 1'b0; wake_alarm = 1'b0;
        wake_handsfree = 1'b0;
        cyc(3);
        wait_ticks(1);
        host_keepalive = 1'b0;
        wait_ticks(T_HOLDLOW-1); cyc(1);
        host_keepalive = 1'b1;
        cyc(5);
        expect_out("R10 short keep-alive drop ignored", E_ON);
        wait_ticks(1);
        host_keepalive = 1'b0;
        wait_ticks(T_HOLDLOW-1); cyc(3);
        expect_out("R10 still running before low timeout", E_ON);
        wait_ticks(1); cyc(3);
        expect_out("R10 keep-alive low shuts down", E_SBY);

        // R9: brownout with recovery, then without
        wait_ticks(1);
        wake_key = 1'b1;
        cyc(4);
        wake_key = 1'b0;
        wait_ticks(1);
        core_ok = 1'b0; core_sag = 1'b1;
        cyc(4);
        expect_out("R9 brownout holds reset", E_SEQ);
        wait_ticks(T_BROWN-1); cyc(3);
        expect_out("R9 brownout before timeout", E_SEQ);
        core_ok = 1'b1; core_sag = 1'b0;
        cyc(4);
        wait_ticks(T_RSTDLY); cyc(3);
        expect_out("R9 recovery resumes reset delay", E_ON);
        wait_ticks(1);
        core_ok = 1'b0; core_sag = 1'b1;
        cyc(4);
        expect_out("R9 sag in hold wait asserts reset", E_SEQ);
        wait_ticks(T_BROWN-1); cyc(3);
        expect_out("R9 brownout waiting", E_SEQ);
        wait_ticks(1); cyc(3);
        expect_out("R9 brownout timeout powers down", E_SBY);

        // R1: asynchronous clear while sequencing
        core_ok = 1'b1; core_sag = 1'b0;
        wait_ticks(1);
        wake_key = 1'b1;
        cyc(4);
        expect_out("R1 precondition sequencing", E_SEQ);
        wake_key = 1'b0;
        #1 batt_above_por = 1'b0;
        #1;
        expect_out("R1 async clear", E_OFF);
        cyc(3);
        expect_out("R1 held off", E_OFF);
        batt_above_por = 1'b1;
        cyc(5);
        expect_out("R3 ready battery goes to standby", E_SBY);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1-flow actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule